// File: doc/BRIEF.md
# JTAG Instruction Register with Data-Register Routing

This block holds the 2-bit instruction of a JTAG test access port and decides which data register is placed in the serial path from TDI to TDO. An external TAP state machine drives one strobe per controller state of interest: test-logic-reset, capture-IR, shift-IR, update-IR, capture-DR, shift-DR and update-DR. Each strobe is sampled on the rising edge of TCK. The block acts on the strobes and on TDI, and it presents the active instruction and the serial output.

There are three data paths. A 1-bit bypass register and an 8-bit user register live inside the block. The boundary register lives outside. For it the block gates the capture, shift and update strobes toward the boundary cells and takes the cells' serial output back in. The serial output is retimed on the falling edge of TCK. An output-enable marks when a pad should drive it and when the pad should float.

The serial path is a plain one-bit-per-clock scan path. It is paced only by TCK and the strobes, so it has no valid/ready handshake and no back-pressure.

Top module: `tap_ir_dr_sel`

## Requirements
- R1: A test-logic-reset strobe sets the active instruction to bypass (code 11) at that rising edge and clears `usr_out` to 0.
- R2: A capture-IR strobe loads the IR shift stage with 01. During the following shift-IR cycles, TDO presents bit 0 first and then bit 1, so the sequence is 1 and then 0.
- R3: Each shift-IR edge moves TDI into bit 1 and bit 1 into bit 0. The active instruction takes the shift stage value only on an update-IR edge and holds at every other edge.
- R4: The opcode map is: 00 extest, 01 user, 10 sample, 11 bypass. `instr` shows the active code.
- R5: With bypass active, capture-DR loads 0 into the 1-bit bypass register. Shift-DR then returns TDI on TDO one cycle later.
- R6: With user active, capture-DR loads 01010101 (0x55) into the 8-bit user register. Shift-DR moves TDI into bit 7 and presents bit 0 on TDO. Update-DR copies the register to `usr_out`. When user is not active, `usr_out` does not change.
- R7: With extest or sample active, `bnd_cap`, `bnd_shf` and `bnd_upd` follow the DR strobes, and TDO follows `bnd_so` during shift-DR. With any other instruction these three outputs stay 0. `bnd_extest` is 1 only while code 00 is active.
- R8: TDO and `tdo_oe` change on the falling edge of TCK. `tdo_oe` is 1 only when shift-IR or shift-DR is present at that falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| st_tlr | input | 1 | Test-logic-reset state strobe |
| st_cap_ir | input | 1 | Capture-IR state strobe |
| st_shf_ir | input | 1 | Shift-IR state strobe |
| st_upd_ir | input | 1 | Update-IR state strobe |
| st_cap_dr | input | 1 | Capture-DR state strobe |
| st_shf_dr | input | 1 | Shift-DR state strobe |
| st_upd_dr | input | 1 | Update-DR state strobe |
| tdi | input | 1 | Serial test data in |
| bnd_so | input | 1 | Serial output of the external boundary chain |
| instr | output | 2 | Active instruction code |
| bnd_extest | output | 1 | Boundary cells drive the pins (extest active) |
| bnd_cap | output | 1 | Capture strobe to the boundary chain |
| bnd_shf | output | 1 | Shift strobe to the boundary chain |
| bnd_upd | output | 1 | Update strobe to the boundary chain |
| usr_out | output | 8 | Update stage of the user register |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | Output enable for the TDO pad |

## Verification
- **Same rising edge:** `instr`, `usr_out` and the internal shift stages all update on the rising edge that samples their strobe. The bench applies each strobe just after a rising edge and reads these results just after the next one.
- **Next falling edge:** TDO and `tdo_oe` are due at the falling edge inside the same cycle as the strobe. They reflect the register contents left by the previous rising edge, so the bench reads them 2 ns after that falling edge.
- **Combinational:** the boundary strobes are combinational from the inputs and are read in that same window.
- **Reference model:** expected scan streams come from a bench model of each register: the capture pattern, then TDI delayed by the register length.

// File: rtl/jtir_pkg.sv
package jtir_pkg;
  localparam int IR_W = 2;

  typedef enum logic [IR_W-1:0] {
    OP_EXTEST = 2'b00,
    OP_USER   = 2'b01,
    OP_SAMPLE = 2'b10,
    OP_BYPASS = 2'b11
  } op_e;

  localparam logic [IR_W-1:0] IR_CAPTURE = 2'b01;
endpackage

// File: rtl/jtir_ireg.sv
module jtir_ireg
  import jtir_pkg::*;
(
  input  logic tck,
  input  logic st_tlr,
  input  logic st_cap,
  input  logic st_shf,
  input  logic st_upd,
  input  logic tdi,
  output logic ir_lsb,
  output op_e  instr
);
  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck) begin
    if (st_cap)      ir_sh <= IR_CAPTURE;
    else if (st_shf) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
  end

  always_ff @(posedge tck) begin
    if (st_tlr)      instr <= OP_BYPASS;
    else if (st_upd) instr <= op_e'(ir_sh);
  end

  assign ir_lsb = ir_sh[0];

  // R1
  a_r1_tlr_bypass: assert property (@(posedge tck) st_tlr |=> instr == OP_BYPASS);
  // R2
  a_r2_cap_pattern: assert property (@(posedge tck) disable iff (st_tlr)
    st_cap |=> ir_sh == IR_CAPTURE);
  // R3
  a_r3_instr_hold: assert property (@(posedge tck) disable iff (st_tlr)
    (!st_upd && !st_tlr) |=> instr == $past(instr));
endmodule

// File: rtl/jtir_dreg.sv
module jtir_dreg
  import jtir_pkg::*;
#(
  parameter int              USR_W   = 8,
  parameter logic [USR_W-1:0] USR_CAP = 8'h55
) (
  input  logic             tck,
  input  logic             st_tlr,
  input  logic             st_cap,
  input  logic             st_shf,
  input  logic             st_upd,
  input  logic             tdi,
  input  op_e              instr,
  output logic             byp_q,
  output logic             usr_lsb,
  output logic [USR_W-1:0] usr_out
);
  logic [USR_W-1:0] usr_sh;
  logic             is_byp, is_usr;

  assign is_byp = (instr == OP_BYPASS);
  assign is_usr = (instr == OP_USER);

  always_ff @(posedge tck) begin
    if (is_byp) begin
      if (st_cap)      byp_q <= 1'b0;
      else if (st_shf) byp_q <= tdi;
    end
  end

  always_ff @(posedge tck) begin
    if (is_usr) begin
      if (st_cap)      usr_sh <= USR_CAP;
      else if (st_shf) usr_sh <= {tdi, usr_sh[USR_W-1:1]};
    end
  end

  always_ff @(posedge tck) begin
    if (st_tlr)                usr_out <= '0;
    else if (st_upd && is_usr) usr_out <= usr_sh;
  end

  assign usr_lsb = usr_sh[0];

  // R5
  a_r5_byp_capture: assert property (@(posedge tck) disable iff (st_tlr)
    (st_cap && instr == OP_BYPASS) |=> byp_q == 1'b0);
  // R6
  a_r6_usr_capture: assert property (@(posedge tck) disable iff (st_tlr)
    (st_cap && instr == OP_USER) |=> usr_sh == USR_CAP);
  // R6
  a_r6_usr_out_hold: assert property (@(posedge tck) disable iff (st_tlr)
    (!(st_upd && instr == OP_USER) && !st_tlr) |=> $stable(usr_out));
endmodule

// File: rtl/jtir_tdo.sv
module jtir_tdo
  import jtir_pkg::*;
(
  input  logic tck,
  input  logic st_shf_ir,
  input  logic st_shf_dr,
  input  op_e  instr,
  input  logic ir_lsb,
  input  logic byp_q,
  input  logic usr_lsb,
  input  logic bnd_so,
  output logic tdo,
  output logic tdo_oe
);
  logic dr_bit;

  always_comb begin
    unique case (instr)
      OP_BYPASS: dr_bit = byp_q;
      OP_USER:   dr_bit = usr_lsb;
      default:   dr_bit = bnd_so;
    endcase
  end

  always_ff @(negedge tck) begin
    tdo_oe <= st_shf_ir | st_shf_dr;
    tdo    <= st_shf_ir ? ir_lsb : dr_bit;
  end
endmodule

// File: rtl/tap_ir_dr_sel.sv
module tap_ir_dr_sel
  import jtir_pkg::*;
#(
  parameter int               USR_W   = 8,
  parameter logic [USR_W-1:0] USR_CAP = 8'h55
) (
  input  logic             tck,
  input  logic             st_tlr,
  input  logic             st_cap_ir,
  input  logic             st_shf_ir,
  input  logic             st_upd_ir,
  input  logic             st_cap_dr,
  input  logic             st_shf_dr,
  input  logic             st_upd_dr,
  input  logic             tdi,
  input  logic             bnd_so,
  output logic [IR_W-1:0]  instr,
  output logic             bnd_extest,
  output logic             bnd_cap,
  output logic             bnd_shf,
  output logic             bnd_upd,
  output logic [USR_W-1:0] usr_out,
  output logic             tdo,
  output logic             tdo_oe
);
  op_e  op;
  logic ir_lsb, byp_q, usr_lsb, bnd_sel;

  jtir_ireg u_ireg (
    .tck(tck), .st_tlr(st_tlr), .st_cap(st_cap_ir), .st_shf(st_shf_ir),
    .st_upd(st_upd_ir), .tdi(tdi), .ir_lsb(ir_lsb), .instr(op)
  );

  jtir_dreg #(.USR_W(USR_W), .USR_CAP(USR_CAP)) u_dreg (
    .tck(tck), .st_tlr(st_tlr), .st_cap(st_cap_dr), .st_shf(st_shf_dr),
    .st_upd(st_upd_dr), .tdi(tdi), .instr(op), .byp_q(byp_q),
    .usr_lsb(usr_lsb), .usr_out(usr_out)
  );

  jtir_tdo u_tdo (
    .tck(tck), .st_shf_ir(st_shf_ir), .st_shf_dr(st_shf_dr), .instr(op),
    .ir_lsb(ir_lsb), .byp_q(byp_q), .usr_lsb(usr_lsb), .bnd_so(bnd_so),
    .tdo(tdo), .tdo_oe(tdo_oe)
  );

  assign bnd_sel    = (op == OP_EXTEST) || (op == OP_SAMPLE);
  assign bnd_extest = (op == OP_EXTEST);
  assign bnd_cap    = st_cap_dr & bnd_sel;
  assign bnd_shf    = st_shf_dr & bnd_sel;
  assign bnd_upd    = st_upd_dr & bnd_sel;
  assign instr      = op;

  // R7
  a_r7_bnd_quiet: assert property (@(posedge tck) disable iff (st_tlr)
    (op == OP_BYPASS || op == OP_USER) |-> !(bnd_cap || bnd_shf || bnd_upd));
endmodule

// File: tb/sim_tap_ir_dr_sel.sv
`timescale 1ns/1ps
module sim_tap_ir_dr_sel;
  localparam logic [6:0] S_NONE = 7'b0000000, S_TLR = 7'b1000000, S_CIR = 7'b0100000,
                         S_SIR = 7'b0010000, S_UIR = 7'b0001000, S_CDR = 7'b0000100,
                         S_SDR = 7'b0000010, S_UDR = 7'b0000001;

  logic clk = 1'b0;
  logic [6:0] st = '0;
  logic tdi = 1'b0, bso = 1'b0;
  logic [1:0] instr;
  logic bnd_extest, bnd_cap, bnd_shf, bnd_upd, tdo, tdo_oe;
  logic [7:0] usr_out;
  int n_chk = 0, n_bad = 0;
  logic [1:0] exp_op;
  logic [7:0] exp_usr;
  logic so, soe, sbc, sbs, sbu;

  always #4 clk = ~clk;

  tap_ir_dr_sel u0 (
    .tck(clk), .st_tlr(st[6]), .st_cap_ir(st[5]), .st_shf_ir(st[4]), .st_upd_ir(st[3]),
    .st_cap_dr(st[2]), .st_shf_dr(st[1]), .st_upd_dr(st[0]), .tdi(tdi), .bnd_so(bso),
    .instr(instr), .bnd_extest(bnd_extest), .bnd_cap(bnd_cap), .bnd_shf(bnd_shf),
    .bnd_upd(bnd_upd), .usr_out(usr_out), .tdo(tdo), .tdo_oe(tdo_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [6:0] s, input logic d, input logic b);
    st = s; tdi = d; bso = b;
    @(negedge clk); #2;
    so = tdo; soe = tdo_oe; sbc = bnd_cap; sbs = bnd_shf; sbu = bnd_upd;
    @(posedge clk); #1;
  endtask

  task automatic scan_ir(input logic [1:0] op, input bit commit);
    tick(S_CIR, 1'b0, 1'b0);
    tick(S_SIR, op[0], 1'b0);
    chk("R2 first ir bit", {soe, so}, 2'b11);
    tick(S_SIR, op[1], 1'b0);
    chk("R2 second ir bit", {soe, so}, 2'b10);
    if (commit) begin
      tick(S_UIR, 1'b0, 1'b0);
      exp_op = op;
    end else tick(S_NONE, 1'b0, 1'b0);
    chk("R3 R4 instr after ir scan", instr, exp_op);
  endtask

  task automatic scan_dr(input int len, input logic [15:0] data, input logic [15:0] bdat);
    logic [7:0] ur;
    logic bp;
    logic bnd;
    bnd = (exp_op == 2'b00) || (exp_op == 2'b10);
    ur = 8'h55; bp = 1'b0;
    tick(S_CDR, 1'b0, 1'b0);
    chk("R7 bnd_cap gating", sbc, bnd);
    chk("R8 oe low in capture", soe, 1'b0);
    for (int i = 0; i < len; i++) begin
      tick(S_SDR, data[i], bdat[i]);
      chk("R7 bnd_shf gating", sbs, bnd);
      case (exp_op)
        2'b11: begin chk("R5 bypass tdo", {soe, so}, {1'b1, bp}); bp = data[i]; end
        2'b01: begin chk("R6 user tdo", {soe, so}, {1'b1, ur[0]}); ur = {data[i], ur[7:1]}; end
        default: chk("R7 boundary tdo", {soe, so}, {1'b1, bdat[i]});
      endcase
    end
    tick(S_UDR, 1'b0, 1'b0);
    chk("R7 bnd_upd gating", sbu, bnd);
    if (exp_op == 2'b01) exp_usr = ur;
    chk("R6 usr_out after update", usr_out, exp_usr);
    chk("R7 bnd_extest", bnd_extest, exp_op == 2'b00);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    exp_op = 2'b11; exp_usr = 8'h00;
    #1;
    tick(S_TLR, 1'b0, 1'b0);
    chk("R1 reset instr", instr, 2'b11);
    chk("R1 reset usr_out", usr_out, 8'h00);
    chk("R8 oe low at reset", soe, 1'b0);
    // directed: user register capture, shift and update
    scan_ir(2'b01, 1'b1);
    scan_dr(8, 16'h00c3, 16'h0000);
    chk("R6 usr_out value", usr_out, 8'hc3);
    tick(S_NONE, 1'b0, 1'b0);
    chk("R8 oe low when idle", soe, 1'b0);
    // R3: scan without update leaves instr
    scan_ir(2'b00, 1'b0);
    // R1: reset from user
    tick(S_TLR, 1'b0, 1'b0);
    exp_op = 2'b11; exp_usr = 8'h00;
    chk("R1 tlr from user", instr, 2'b11);
    chk("R1 tlr clears usr_out", usr_out, 8'h00);
    // R5 bypass, R6 no effect while not user
    scan_dr(6, 16'h002d, 16'h0000);
    // R7 extest then sample
    scan_ir(2'b00, 1'b1);
    scan_dr(5, 16'h0000, 16'h0016);
    scan_ir(2'b10, 1'b1);
    scan_dr(4, 16'h000f, 16'h0009);
    // random
    for (int k = 0; k < 60; k++) begin
      logic [1:0] op;
      op = 2'($urandom);
      scan_ir(op, ($urandom % 4) != 0);
      scan_dr(1 + ($urandom % 12), 16'($urandom), 16'($urandom));
      if (($urandom % 8) == 0) begin
        tick(S_TLR, 1'b0, 1'b0);
        exp_op = 2'b11; exp_usr = 8'h00;
        chk("R1 random tlr", {instr, usr_out}, {2'b11, 8'h00});
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule